// File: doc/BRIEF.md
# Scan Launch/Capture Sequencer for At-Speed Delay Test

This block drives an ordinary multiplexed scan chain, one with no hold latches, through one two-vector delay test. It shifts the first vector into the chain at a slow rate. It then creates the second vector, fires a capture edge exactly one rated period later, and shifts the response back out at the slow rate. The chain's clock is gated by a clock-enable output. Each shift or functional update happens at the end of a cycle in which that enable is high.

Because V2 cannot be loaded freely on such a chain, the block offers two ways to derive it from V1. In shift-launch mode, V2 comes from one extra single-bit shift. In that mode the scan-enable must drop during the short launch-to-capture window. In functional-launch mode, one normal-mode update applied to V1 produces V2. A second normal update then captures the result.

The primary inputs of the logic change from the first set of values to the second at the launch update. A small stand-in logic cone and the scan cells are included so that the sequence can be exercised. The cone has a modelled per-output settling delay, and a test input can make one of its outputs slow.

Top module: `scan_delay_tester`

## Requirements
- R1: While and right after reset, `scan_en`, `clk_en` and `done` are low and `scan_out` is 0. Without `start`, no enable pulse appears.
- R2: After `start` is accepted in idle, `scan_en` rises. Exactly N shift pulses load the chain. On each shift, `scan_in` enters cell 0, every cell takes the value of the cell below it, and `scan_out` shows cell N-1. The first bit shifted in ends up in cell N-1.
- R3: With `mode_los`=1, the launch is one more pulse with `scan_en` high, which shifts `scan_in` into cell 0. `scan_en` then falls before the next pulse, so the capture is a functional update.
- R4: With `mode_los`=0, `scan_en` falls after the last load pulse. Both the launch pulse and the capture pulse are functional updates.
- R5: The capture pulse comes exactly RATED_DIV cycles after the launch pulse. Every other pair of consecutive pulses within a test is SLOW_DIV cycles apart.
- R6: The cone sees `pi_v1` up to and including the launch update, and sees `pi_v2` from then until the capture.
- R7: The functional next value of cell i is cell[(i+1) mod N] XOR (cell[i] AND pi[i mod PI_W]).
- R8: A cone output that changed at the launch is captured with its new value only if its path delay, in cycles, is at most RATED_DIV. Otherwise the capture holds the value computed from the pre-launch state and inputs. Outputs have delay NOM_DLY (at most RATED_DIV). With `fault_en`=1, output FAULT_BIT has delay SLOW_DLY, which is greater than RATED_DIV and at most SLOW_DIV.
- R9: After the capture, `scan_en` rises and N slow shift pulses unload the chain. Just before the k-th unload pulse (k from 0), `scan_out` shows captured bit N-1-k.
- R10: `done` is high for exactly one cycle, the cycle after the final unload pulse. `start` is ignored while a test is running.
- R11: `clk_en` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one test when idle |
| mode_los | input | 1 | 1: launch by extra shift, 0: launch by functional update |
| pi_v1 | input | PI_W | Primary input values for the first vector |
| pi_v2 | input | PI_W | Primary input values for the second vector |
| fault_en | input | 1 | Make cone output FAULT_BIT slow |
| scan_in | input | 1 | Serial data into cell 0 |
| scan_en | output | 1 | 1: cells shift, 0: cells take cone outputs |
| clk_en | output | 1 | Single-cycle enable for each chain update |
| scan_out | output | 1 | Serial data from cell N-1 |
| done | output | 1 | One-cycle pulse after the last unload shift |

## Verification
Suppose the sequencer's phase or pulse counter is wrong. Then the enable pulses come at a wrong spacing or in a wrong number, and the gap between two pulses shows it within one slow period. Suppose instead scan-enable is in the wrong state at the launch or the capture. Then V2 or the captured vector differs from the golden model, and this shows up as wrong serial bits during the unload, N slow periods later. A wrong settling model in the cone shows only in the unloaded value of the slow bit, which is why each launch mode is run both with and without the slow output.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_LAUNCH,
    PH_CAPTURE,
    PH_UNLOAD,
    PH_FIN
  } phase_t;
endpackage

// File: rtl/sdt_ctrl.sv
module sdt_ctrl
  import sdt_pkg::*;
#(
  parameter int N         = 8,
  parameter int SLOW_DIV  = 8,
  parameter int RATED_DIV = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic mode_los,
  output logic scan_en,
  output logic clk_en,
  output logic done,
  output logic pi_sel,
  output logic busy
);
  localparam int CW = $clog2(N + 1);
  localparam int TW = $clog2(SLOW_DIV + 1);
  localparam logic [TW-1:0] T_FIRST = TW'(SLOW_DIV - 2);
  localparam logic [TW-1:0] T_SLOW  = TW'(SLOW_DIV - 1);
  localparam logic [TW-1:0] T_RATED = TW'(RATED_DIV - 1);
  localparam logic [CW-1:0] C_LAST  = CW'(N - 1);

  phase_t          ph, pk;
  logic [TW-1:0]   tmr;
  logic [CW-1:0]   cnt;
  logic            los_q, se_q, cke_q, done_q, sel_q;
  logic            se_next;

  // scan-enable wanted for the pulse that the phase register now points at
  always_comb begin
    se_next = (ph == PH_LOAD) || (ph == PH_UNLOAD) || ((ph == PH_LAUNCH) && los_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      pk     <= PH_IDLE;
      tmr    <= '0;
      cnt    <= '0;
      los_q  <= 1'b0;
      se_q   <= 1'b0;
      cke_q  <= 1'b0;
      done_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      cke_q  <= 1'b0;
      done_q <= 1'b0;
      if (cke_q) begin
        if (pk == PH_LAUNCH) sel_q <= 1'b1;
        se_q <= se_next;
      end
      case (ph)
        PH_IDLE: begin
          if (start) begin
            ph    <= PH_LOAD;
            cnt   <= C_LAST;
            tmr   <= T_FIRST;
            se_q  <= 1'b1;
            los_q <= mode_los;
            sel_q <= 1'b0;
          end
        end
        PH_FIN: begin
          if (cke_q) begin
            done_q <= 1'b1;
            ph     <= PH_IDLE;
          end
        end
        default: begin
          if (tmr == '0) begin
            cke_q <= 1'b1;
            pk    <= ph;
            tmr   <= T_SLOW;
            case (ph)
              PH_LOAD: begin
                if (cnt == '0) ph <= PH_LAUNCH;
                else           cnt <= cnt - 1'b1;
              end
              PH_LAUNCH: begin
                ph  <= PH_CAPTURE;
                tmr <= T_RATED;
              end
              PH_CAPTURE: begin
                ph  <= PH_UNLOAD;
                cnt <= C_LAST;
              end
              PH_UNLOAD: begin
                if (cnt == '0) ph <= PH_FIN;
                else           cnt <= cnt - 1'b1;
              end
              default: ph <= PH_IDLE;
            endcase
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
      endcase
    end
  end

  assign scan_en = se_q;
  assign clk_en  = cke_q;
  assign done    = done_q;
  assign pi_sel  = sel_q;
  assign busy    = (ph != PH_IDLE);
endmodule

// File: rtl/sdt_chain.sv
module sdt_chain #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic         se,
  input  logic         sin,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] shift_src;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cell
      if (g == 0) begin : g_head
        assign shift_src[g] = sin;
      end else begin : g_body
        assign shift_src[g] = q[g-1];
      end
      always_ff @(posedge clk) begin
        if (rst)      q[g] <= 1'b0;
        else if (upd) q[g] <= se ? shift_src[g] : d[g];
      end
    end
  endgenerate
endmodule

// File: rtl/sdt_cone.sv
module sdt_cone #(
  parameter int N         = 8,
  parameter int PI_W      = 4,
  parameter int NOM_DLY   = 2,
  parameter int SLOW_DLY  = 5,
  parameter int FAULT_BIT = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd,
  input  logic            fault_en,
  input  logic [N-1:0]    st,
  input  logic [PI_W-1:0] pi,
  output logic [N-1:0]    d
);
  localparam int AW = $clog2(SLOW_DLY + 1);
  localparam logic [AW-1:0] NEED_NOM  = AW'(NOM_DLY - 1);
  localparam logic [AW-1:0] NEED_SLOW = AW'(SLOW_DLY - 1);

  logic [AW-1:0]   age;
  logic [N-1:0]    old_st;
  logic [PI_W-1:0] old_pi;
  logic [N-1:0]    f_new, f_old;

  function automatic logic [N-1:0] cone_f(input logic [N-1:0] s, input logic [PI_W-1:0] p);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = s[(i + 1) % N] ^ (s[i] & p[i % PI_W]);
    return r;
  endfunction

  // cycles elapsed since the last chain update, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      age    <= '1;
      old_st <= '0;
      old_pi <= '0;
    end else if (upd) begin
      age    <= '0;
      old_st <= st;
      old_pi <= pi;
    end else if (age != '1) begin
      age <= age + 1'b1;
    end
  end

  always_comb begin
    f_new = cone_f(st, pi);
    f_old = cone_f(old_st, old_pi);
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_out
      logic [AW-1:0] need;
      if (g == FAULT_BIT) begin : g_slow
        assign need = fault_en ? NEED_SLOW : NEED_NOM;
      end else begin : g_nom
        assign need = NEED_NOM;
      end
      assign d[g] = (age >= need) ? f_new[g] : f_old[g];
    end
  endgenerate
endmodule

// File: rtl/scan_delay_tester.sv
module scan_delay_tester #(
  parameter int N         = 8,
  parameter int PI_W      = 4,
  parameter int SLOW_DIV  = 8,
  parameter int RATED_DIV = 3,
  parameter int NOM_DLY   = 2,
  parameter int SLOW_DLY  = 5,
  parameter int FAULT_BIT = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            mode_los,
  input  logic [PI_W-1:0] pi_v1,
  input  logic [PI_W-1:0] pi_v2,
  input  logic            fault_en,
  input  logic            scan_in,
  output logic            scan_en,
  output logic            clk_en,
  output logic            scan_out,
  output logic            done
);
  logic            pi_sel, busy;
  logic [PI_W-1:0] pi_cur;
  logic [N-1:0]    cells, cone_d;

  sdt_ctrl #(.N(N), .SLOW_DIV(SLOW_DIV), .RATED_DIV(RATED_DIV)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .mode_los(mode_los),
    .scan_en(scan_en), .clk_en(clk_en), .done(done),
    .pi_sel(pi_sel), .busy(busy)
  );

  assign pi_cur = pi_sel ? pi_v2 : pi_v1;

  sdt_cone #(.N(N), .PI_W(PI_W), .NOM_DLY(NOM_DLY), .SLOW_DLY(SLOW_DLY),
             .FAULT_BIT(FAULT_BIT)) u_cone (
    .clk(clk), .rst(rst), .upd(clk_en), .fault_en(fault_en),
    .st(cells), .pi(pi_cur), .d(cone_d)
  );

  sdt_chain #(.N(N)) u_chain (
    .clk(clk), .rst(rst), .upd(clk_en), .se(scan_en),
    .sin(scan_in), .d(cone_d), .q(cells)
  );

  assign scan_out = cells[N-1];
endmodule

// File: rtl/sdt_chk.sv
module sdt_chk #(
  parameter int SLOW_DIV  = 8,
  parameter int RATED_DIV = 3
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic mode_los,
  input logic busy,
  input logic cke,
  input logic se,
  input logic done
);
  localparam int GW = $clog2(SLOW_DIV + 2);
  localparam logic [GW-1:0] G_SLOW  = GW'(SLOW_DIV);
  localparam logic [GW-1:0] G_RATED = GW'(RATED_DIV);

  logic [GW-1:0] gap;
  logic          first, se_last, los_m;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap     <= '0;
      first   <= 1'b1;
      se_last <= 1'b0;
      los_m   <= 1'b0;
    end else begin
      if (start && !busy) begin
        first <= 1'b1;
        los_m <= mode_los;
      end
      if (cke) begin
        gap     <= GW'(1);
        first   <= 1'b0;
        se_last <= se;
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
    end
  end

  // R11
  cke_single_chk: assert property (@(posedge clk) disable iff (rst) cke |=> !cke);
  // R5
  pulse_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cke && !first) |-> (gap == G_SLOW || gap == G_RATED));
  // R5
  rated_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (cke && !first && gap == G_RATED) |-> !se);
  // R3
  los_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (cke && !first && gap == G_RATED && los_m) |-> se_last);
  // R4
  loc_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (cke && !first && gap == G_RATED && !los_m) |-> !se_last);
  // R2
  se_change_chk: assert property (@(posedge clk) disable iff (rst)
    (se != $past(se)) |-> ($past(cke) || $past(start && !busy)));
  // R10
  done_after_shift_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(cke) && $past(se)));
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
endmodule

bind scan_delay_tester sdt_chk #(.SLOW_DIV(SLOW_DIV), .RATED_DIV(RATED_DIV)) u_sdt_chk (
  .clk(clk), .rst(rst), .start(start), .mode_los(mode_los), .busy(busy),
  .cke(clk_en), .se(scan_en), .done(done)
);

// File: tb/test_scan_delay_tester.sv
module test_scan_delay_tester;
  localparam int N = 8, PI_W = 4, SLOW = 8, RATED = 3, NOM = 2, SLOWD = 5, FB = 0;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, mode_los = 1'b0, fault_en = 1'b0, scan_in = 1'b0;
  logic [PI_W-1:0] pi_v1 = '0, pi_v2 = '0;
  logic scan_en, clk_en, scan_out, done;
  int total = 0, bad = 0, cyc = 0;

  scan_delay_tester #(.N(N), .PI_W(PI_W), .SLOW_DIV(SLOW), .RATED_DIV(RATED),
                      .NOM_DLY(NOM), .SLOW_DLY(SLOWD), .FAULT_BIT(FB)) i_scan_delay_tester (
    .clk(clk), .rst(rst), .start(start), .mode_los(mode_los), .pi_v1(pi_v1), .pi_v2(pi_v2),
    .fault_en(fault_en), .scan_in(scan_in), .scan_en(scan_en), .clk_en(clk_en),
    .scan_out(scan_out), .done(done)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] gold_f(input logic [N-1:0] s, input logic [PI_W-1:0] p);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = s[(i + 1) % N] ^ (s[i] & p[i % PI_W]);
    return r;
  endfunction

  task automatic run_pat(input bit los, input bit flt, input logic [N-1:0] v1,
                         input logic [PI_W-1:0] p1, input logic [PI_W-1:0] p2,
                         input bit lb, input bit poke, input string name);
    logic [N-1:0] v2, good, stale, exp_cap, got;
    int se_err, gap_err, last;
    bit exp_se;
    v2    = los ? {v1[N-2:0], lb} : gold_f(v1, p1);
    good  = gold_f(v2, p2);
    stale = gold_f(v1, p1);
    exp_cap = good;
    if (flt) exp_cap[FB] = stale[FB];
    got = '0; se_err = 0; gap_err = 0; last = 0;
    mode_los = los; fault_en = flt; pi_v1 = p1; pi_v2 = p2;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int p = 0; p < 2 * N + 2; p++) begin
      scan_in = (p < N) ? v1[N-1-p] : ((p == N) ? lb : 1'b0);
      do @(negedge clk); while (!clk_en);
      exp_se = (p < N) || (p > N + 1) || ((p == N) && los);
      if (scan_en !== exp_se) se_err++;
      if (p > 0 && (cyc - last) != ((p == N + 1) ? RATED : SLOW)) gap_err++;
      last = cyc;
      if (p >= N + 2) got[N-1-(p-N-2)] = scan_out;
      @(posedge clk); #1;
      if (poke && p == 2) begin
        start = 1'b1; @(posedge clk); #1; start = 1'b0;
      end
    end
    @(negedge clk);
    check(done === 1'b1, "R10", {name, " done after last unload"}, done, 1);
    @(negedge clk);
    check(done === 1'b0 && clk_en === 1'b0, "R10", {name, " done one cycle, idle"}, done, 0);
    check(se_err == 0, los ? "R3" : "R4", {name, " scan_en per pulse (R2 load, R9 unload)"}, se_err, 0);
    check(gap_err == 0, "R5", {name, " pulse spacing"}, gap_err, 0);
    check(got == exp_cap, flt ? "R8" : "R7", {name, " captured vector, R6 inputs, R9 order"}, got, exp_cap);
  endtask

  task automatic t_reset();
    int pulses = 0;
    check(scan_en === 1'b0 && clk_en === 1'b0 && done === 1'b0 && scan_out === 1'b0,
          "R1", "outputs after reset", {scan_en, clk_en, done, scan_out}, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (clk_en !== 1'b0) pulses++;
    end
    check(pulses == 0, "R1", "no pulses without start", pulses, 0);
  endtask

  task automatic t_los_clean();  run_pat(1, 0, 8'hA5, 4'h3, 4'hD, 1, 0, "los clean"); endtask
  task automatic t_loc_clean();  run_pat(0, 0, 8'hA5, 4'h3, 4'hD, 0, 0, "loc clean"); endtask
  task automatic t_los_slow();   run_pat(1, 1, 8'hA5, 4'h3, 4'hD, 1, 0, "los slow"); endtask
  task automatic t_loc_slow();   run_pat(0, 1, 8'hA5, 4'h3, 4'hD, 0, 0, "loc slow"); endtask
  task automatic t_los_other();  run_pat(1, 1, 8'h3C, 4'hA, 4'h5, 0, 0, "los alt"); endtask
  task automatic t_busy_start(); run_pat(0, 0, 8'h96, 4'hF, 4'h6, 0, 1, "start while busy"); endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_los_clean();
    t_loc_clean();
    t_los_slow();
    t_loc_slow();
    t_los_other();
    t_busy_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule